// File: doc/BRIEF.md
# Multi-Pin GPIO Register Bank

This block is a memory-mapped GPIO controller for a parameterised number of pins (95 by default). A simple 32-bit register port reaches two kinds of state that share one address space. Bitmap words hold one bit per pin across three consecutive 32-bit words: firmware ownership, direct-interrupt routing, interrupt status and interrupt enable. A single global control word sits beside them. Each pin also has a pair of 32-bit configuration words. The first holds the output level, the sampled input level, the trigger mode bits, the direction and the use select. The second holds the input-sense disable bit and the weak-pull select.

From this state the block drives each pad's output value and output enable. It also brings out each pin's mux select, pull select and trigger configuration to the pad ring and to a separate edge/level detector. That detector reports events back on `irq_set`, and the bank latches them as sticky status bits. Pad inputs pass through a two-flop synchroniser before software can read them.

Top module: `gpio_bank_top`

## Requirements
- R1: After reset every pin is in native mode (use select 0), set to input (direction bit 1), with input sensing disabled and no pull. The first configuration word reads 0x00000004, the second reads 0x00000004, and all bitmap words and the control word read 0.
- R2: Bitmap banks start at ownership 0x000, routing 0x010, status 0x080 and enable 0x090. Pin n sits in the word at base + 4*(n/32), bit n mod 32. Bits above the last pin in the final word read 0, and writes to them are ignored. The control word at 0x07C holds all 32 written bits.
- R3: Pin n's first configuration word is at 0x100 + 8*n. Bit 31 is the output level, bit 4 the trigger select (1 level, 0 edge), bit 3 the trigger invert, bit 2 the direction (1 input), and bits 1:0 the use select. All of these read back as written, and bits 4 and 3 drive `trig_level` and `trig_invert`.
- R4: Bit 30 of the first configuration word is read-only. It shows the pad input two clock edges after the change, and reads 0 while input sensing is disabled (bit 2 of the second word at 0x104 + 8*n).
- R5: `pad_oe[n]` is 1 exactly when pin n's use select is 1 (GPIO) and its direction bit is 0. `pad_out[n]` equals its output-level bit.
- R6: `pad_mux[2n+1:2n]` equals pin n's use select, and `pad_pull[2n+1:2n]` equals bits 1:0 of its second word (0 none, 1 down, 2 up).
- R7: A read from an unmapped, misaligned or out-of-range-pin address returns 0, and a write to such an address changes no state.
- R8: A 1 on `irq_set[n]` sets status bit n. The bit stays set until a write of 1 to that bit of the status word clears it. If a set and a clear arrive in the same cycle, the set wins.
- R9: A read presented in one cycle returns its data with `bus_rvalid` high in the next cycle only. The read returns the state as it was before any write made in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 write, 0 read |
| bus_addr | input | 10 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid |
| pad_in | input | 95 | Raw pad input levels |
| pad_out | output | 95 | Pad output levels |
| pad_oe | output | 95 | Pad output enables |
| pad_mux | output | 190 | Per-pin use select, 2 bits each |
| pad_pull | output | 190 | Per-pin weak-pull select, 2 bits each |
| trig_level | output | 95 | Per-pin level/edge trigger select |
| trig_invert | output | 95 | Per-pin trigger invert |
| irq_set | input | 95 | Event pulses from the detector |
| irq_status | output | 95 | Sticky interrupt status |
| irq_enable | output | 95 | Interrupt enable bitmap |
| irq_route | output | 95 | Direct-routing bitmap |
| fw_owned | output | 95 | Ownership bitmap |
| ctrl_word | output | 32 | Global control word |

## Verification
Register writes reach the pad, mux, pull and trigger outputs, the readable state and the status bits at the clock edge that takes them, so those outputs are due one edge after the write is presented. Read data appears one edge after the read request, and it reflects state from before that edge. Bit 30 follows the pad two edges after the pad input changes. The bench's behavioural model advances once per rising edge in the same order (read, then write, then synchroniser shift, then status set/clear). It compares every output a quarter period after the edge, so each result is checked in exactly the cycle it is due.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam logic [15:0] OWN_BASE   = 16'h000;
  localparam logic [15:0] ROUTE_BASE = 16'h010;
  localparam logic [15:0] GCTL_ADDR  = 16'h07C;
  localparam logic [15:0] STAT_BASE  = 16'h080;
  localparam logic [15:0] IEN_BASE   = 16'h090;
  localparam logic [15:0] CFG_BASE   = 16'h100;

  typedef enum logic [2:0] {
    RK_NONE, RK_OWN, RK_ROUTE, RK_GCTL, RK_STAT, RK_IEN, RK_CFG_A, RK_CFG_B
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e   kind;
    logic [15:0] index;
  } reg_hit_t;

  typedef struct packed {
    logic       out_lvl;
    logic       trig_level;
    logic       trig_invert;
    logic       dir_in;
    logic [1:0] use_sel;
    logic       sense_off;
    logic [1:0] pull_sel;
  } pin_cfg_t;

  localparam pin_cfg_t CFG_RESET = '{out_lvl: 1'b0, trig_level: 1'b0, trig_invert: 1'b0,
                                     dir_in: 1'b1, use_sel: 2'd0, sense_off: 1'b1,
                                     pull_sel: 2'd0};

  function automatic logic in_bank(input logic [15:0] a, input logic [15:0] base,
                                   input int nwords);
    return (a >= base) && (a < base + 16'(4 * nwords));
  endfunction

  // Classify a byte address: which register kind and which word / pin index.
  function automatic reg_hit_t decode_addr(input logic [15:0] a, input int npins);
    reg_hit_t    h;
    logic [15:0] off;
    int          nw;
    h.kind  = RK_NONE;
    h.index = '0;
    nw      = (npins + 31) / 32;
    off     = a - CFG_BASE;
    if (a[1:0] == 2'b00) begin
      if (a >= CFG_BASE) begin
        if (int'(off >> 3) < npins) begin
          h.index = off >> 3;
          h.kind  = off[2] ? RK_CFG_B : RK_CFG_A;
        end
      end else if (a == GCTL_ADDR) begin
        h.kind = RK_GCTL;
      end else if (in_bank(a, OWN_BASE, nw)) begin
        h.kind = RK_OWN;   h.index = (a - OWN_BASE) >> 2;
      end else if (in_bank(a, ROUTE_BASE, nw)) begin
        h.kind = RK_ROUTE; h.index = (a - ROUTE_BASE) >> 2;
      end else if (in_bank(a, STAT_BASE, nw)) begin
        h.kind = RK_STAT;  h.index = (a - STAT_BASE) >> 2;
      end else if (in_bank(a, IEN_BASE, nw)) begin
        h.kind = RK_IEN;   h.index = (a - IEN_BASE) >> 2;
      end
    end
    return h;
  endfunction

  function automatic pin_cfg_t write_cfg_a(input pin_cfg_t c, input logic [31:0] d);
    pin_cfg_t n;
    n             = c;
    n.out_lvl     = d[31];
    n.trig_level  = d[4];
    n.trig_invert = d[3];
    n.dir_in      = d[2];
    n.use_sel     = d[1:0];
    return n;
  endfunction

  function automatic pin_cfg_t write_cfg_b(input pin_cfg_t c, input logic [31:0] d);
    pin_cfg_t n;
    n           = c;
    n.sense_off = d[2];
    n.pull_sel  = d[1:0];
    return n;
  endfunction

  function automatic logic [31:0] read_cfg_a(input pin_cfg_t c, input logic in_lvl);
    return {c.out_lvl, in_lvl, 25'd0, c.trig_level, c.trig_invert, c.dir_in, c.use_sel};
  endfunction

  function automatic logic [31:0] read_cfg_b(input pin_cfg_t c);
    return {29'd0, c.sense_off, c.pull_sel};
  endfunction

  function automatic logic pad_drives(input pin_cfg_t c);
    return (c.use_sel == 2'b01) && !c.dir_in;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 95
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      sync_out <= '0;
    end else begin
      stage1_q <= async_in;
      sync_out <= stage1_q;
    end
  end
endmodule

// File: rtl/gpio_pin_slice.sv
module gpio_pin_slice
  import gpio_bank_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_a,
  input  logic        wr_b,
  input  logic [31:0] wdata,
  output pin_cfg_t    cfg_q,
  output logic        pad_out,
  output logic        pad_oe,
  output logic [1:0]  mux_sel,
  output logic [1:0]  pull_sel,
  output logic        trig_level,
  output logic        trig_invert
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg_q <= CFG_RESET;
    else if (wr_a)  cfg_q <= write_cfg_a(cfg_q, wdata);
    else if (wr_b)  cfg_q <= write_cfg_b(cfg_q, wdata);
  end

  assign pad_out     = cfg_q.out_lvl;
  assign pad_oe      = pad_drives(cfg_q);
  assign mux_sel     = cfg_q.use_sel;
  assign pull_sel    = cfg_q.pull_sel;
  assign trig_level  = cfg_q.trig_level;
  assign trig_invert = cfg_q.trig_invert;
endmodule

// File: rtl/gpio_bitmap_bank.sv
module gpio_bitmap_bank
  import gpio_bank_pkg::*;
#(
  parameter int NPINS  = 95,
  parameter int NWORDS = (NPINS + 31) / 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_own,
  input  logic             wr_route,
  input  logic             wr_stat,
  input  logic             wr_ien,
  input  logic [15:0]      wsel,
  input  logic [31:0]      wdata,
  input  logic [NPINS-1:0] irq_set,
  output logic [NPINS-1:0] own_q,
  output logic [NPINS-1:0] route_q,
  output logic [NPINS-1:0] stat_q,
  output logic [NPINS-1:0] ien_q,
  output logic [NPINS-1:0] stat_clr
);
  localparam int LANES_W = NWORDS * 32;

  logic [LANES_W-1:0] lane_full, data_full;
  logic [NPINS-1:0]   lane, bits;

  always_comb begin
    lane_full = '0;
    data_full = '0;
    for (int w = 0; w < NWORDS; w++) begin
      if (wsel == 16'(w)) begin
        lane_full[w*32 +: 32] = '1;
        data_full[w*32 +: 32] = wdata;
      end
    end
  end

  assign lane     = lane_full[NPINS-1:0];
  assign bits     = data_full[NPINS-1:0];
  assign stat_clr = wr_stat ? (bits & lane) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q   <= '0;
      route_q <= '0;
      stat_q  <= '0;
      ien_q   <= '0;
    end else begin
      if (wr_own)   own_q   <= (own_q   & ~lane) | (bits & lane);
      if (wr_route) route_q <= (route_q & ~lane) | (bits & lane);
      if (wr_ien)   ien_q   <= (ien_q   & ~lane) | (bits & lane);
      stat_q <= (stat_q & ~stat_clr) | irq_set;
    end
  end
endmodule

// File: rtl/gpio_bank_top.sv
module gpio_bank_top
  import gpio_bank_pkg::*;
#(
  parameter int NPINS  = 95,
  parameter int ADDR_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_write,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               bus_rvalid,
  input  logic [NPINS-1:0]   pad_in,
  output logic [NPINS-1:0]   pad_out,
  output logic [NPINS-1:0]   pad_oe,
  output logic [2*NPINS-1:0] pad_mux,
  output logic [2*NPINS-1:0] pad_pull,
  output logic [NPINS-1:0]   trig_level,
  output logic [NPINS-1:0]   trig_invert,
  input  logic [NPINS-1:0]   irq_set,
  output logic [NPINS-1:0]   irq_status,
  output logic [NPINS-1:0]   irq_enable,
  output logic [NPINS-1:0]   irq_route,
  output logic [NPINS-1:0]   fw_owned,
  output logic [31:0]        ctrl_word
);
  localparam int NWORDS  = (NPINS + 31) / 32;
  localparam int LANES_W = NWORDS * 32;

  // Named events for the checker.
  reg_hit_t         hit;
  logic             wr_fire, rd_fire, addr_unused;
  logic [NPINS-1:0] cfg_wr_a, cfg_wr_b, sync_q, stat_clr_w;
  pin_cfg_t         cfg_q [NPINS];

  assign hit         = decode_addr(16'(bus_addr), NPINS);
  assign wr_fire     = bus_sel && bus_write;
  assign rd_fire     = bus_sel && !bus_write;
  assign addr_unused = (hit.kind == RK_NONE);

  gpio_in_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pad_in), .sync_out(sync_q)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    assign cfg_wr_a[p] = wr_fire && (hit.kind == RK_CFG_A) && (hit.index == 16'(p));
    assign cfg_wr_b[p] = wr_fire && (hit.kind == RK_CFG_B) && (hit.index == 16'(p));
    gpio_pin_slice u_pin (
      .clk(clk), .rst_n(rst_n), .wr_a(cfg_wr_a[p]), .wr_b(cfg_wr_b[p]), .wdata(bus_wdata),
      .cfg_q(cfg_q[p]), .pad_out(pad_out[p]), .pad_oe(pad_oe[p]),
      .mux_sel(pad_mux[2*p +: 2]), .pull_sel(pad_pull[2*p +: 2]),
      .trig_level(trig_level[p]), .trig_invert(trig_invert[p])
    );
  end

  gpio_bitmap_bank #(.NPINS(NPINS), .NWORDS(NWORDS)) u_bmp (
    .clk(clk), .rst_n(rst_n),
    .wr_own(wr_fire && hit.kind == RK_OWN),
    .wr_route(wr_fire && hit.kind == RK_ROUTE),
    .wr_stat(wr_fire && hit.kind == RK_STAT),
    .wr_ien(wr_fire && hit.kind == RK_IEN),
    .wsel(hit.index), .wdata(bus_wdata), .irq_set(irq_set),
    .own_q(fw_owned), .route_q(irq_route), .stat_q(irq_status), .ien_q(irq_enable),
    .stat_clr(stat_clr_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              ctrl_word <= '0;
    else if (wr_fire && hit.kind == RK_GCTL) ctrl_word <= bus_wdata;
  end

  // Read path: pick the addressed pin and word, then format.
  logic [LANES_W-1:0] own_x, route_x, stat_x, ien_x;
  logic [31:0]        own_w, route_w, stat_w, ien_w, rd_word;
  pin_cfg_t           sel_cfg;
  logic               sel_in;

  always_comb begin
    own_x = '0; route_x = '0; stat_x = '0; ien_x = '0;
    own_x[NPINS-1:0]   = fw_owned;
    route_x[NPINS-1:0] = irq_route;
    stat_x[NPINS-1:0]  = irq_status;
    ien_x[NPINS-1:0]   = irq_enable;
    own_w = '0; route_w = '0; stat_w = '0; ien_w = '0;
    for (int w = 0; w < NWORDS; w++) begin
      if (hit.index == 16'(w)) begin
        own_w   = own_x[w*32 +: 32];
        route_w = route_x[w*32 +: 32];
        stat_w  = stat_x[w*32 +: 32];
        ien_w   = ien_x[w*32 +: 32];
      end
    end
    sel_cfg = CFG_RESET;
    sel_in  = 1'b0;
    for (int p = 0; p < NPINS; p++) begin
      if (hit.index == 16'(p)) begin
        sel_cfg = cfg_q[p];
        sel_in  = sync_q[p];
      end
    end
    case (hit.kind)
      RK_OWN:   rd_word = own_w;
      RK_ROUTE: rd_word = route_w;
      RK_STAT:  rd_word = stat_w;
      RK_IEN:   rd_word = ien_w;
      RK_GCTL:  rd_word = ctrl_word;
      RK_CFG_A: rd_word = read_cfg_a(sel_cfg, sel_in && !sel_cfg.sense_off);
      RK_CFG_B: rd_word = read_cfg_b(sel_cfg);
      default:  rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd_fire;
      if (rd_fire) bus_rdata <= rd_word;
    end
  end
endmodule

// File: rtl/gpio_bank_checks.sv
module gpio_bank_checks #(
  parameter int NPINS = 95
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_write,
  input logic [31:0]      bus_rdata,
  input logic             bus_rvalid,
  input logic             addr_unused,
  input logic             wr_fire,
  input logic [NPINS-1:0] pad_oe,
  input logic [NPINS-1:0] irq_set,
  input logic [NPINS-1:0] irq_status,
  input logic [NPINS-1:0] stat_clr
);
  logic [NPINS-1:0] keep;
  assign keep = irq_status & ~stat_clr;

  assert_read_answered_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_write) |=> bus_rvalid);

  assert_no_spurious_rvalid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> $past(bus_sel && !bus_write));

  assert_unused_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_write && addr_unused) |=> (bus_rdata == 32'd0));

  assert_status_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_status & $past(keep)) == $past(keep)));

  assert_status_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_status & $past(irq_set)) == $past(irq_set)));

  assert_oe_moves_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe != $past(pad_oe)) |-> $past(wr_fire));
endmodule

bind gpio_bank_top gpio_bank_checks #(.NPINS(NPINS)) i_checks (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_write(bus_write),
  .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .addr_unused(addr_unused),
  .wr_fire(wr_fire), .pad_oe(pad_oe), .irq_set(irq_set), .irq_status(irq_status),
  .stat_clr(stat_clr_w)
);

// File: tb/test_gpio_bank_top.sv
module test_gpio_bank_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 95;

  logic          clk = 0, rst_n = 0;
  logic          bus_sel = 0, bus_write = 0;
  logic [9:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0, bus_rdata, ctrl_word;
  logic          bus_rvalid;
  logic [NP-1:0] pad_in = '0, irq_set = '0;
  logic [NP-1:0] pad_out, pad_oe, trig_level, trig_invert, irq_status, irq_enable, irq_route, fw_owned;
  logic [2*NP-1:0] pad_mux, pad_pull;

  gpio_bank_top i_gpio_bank_top (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  string phase = "R1";

  // Behavioural model state.
  bit       m_out[NP], m_trig[NP], m_inv[NP], m_dir[NP], m_off[NP];
  bit [1:0] m_use[NP], m_pull[NP];
  bit       m_bmp[4][96];        // 0 own, 1 route, 2 status, 3 enable
  bit [31:0] m_gctl;
  bit       s1[NP], s2[NP];
  bit       e_rvalid;
  bit [31:0] e_rdata;

  task automatic check(string req, string what, logic [191:0] act, logic [191:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int p = 0; p < NP; p++) begin
      m_out[p] = 0; m_trig[p] = 0; m_inv[p] = 0; m_dir[p] = 1; m_off[p] = 1;
      m_use[p] = 0; m_pull[p] = 0; s1[p] = 0; s2[p] = 0;
    end
    for (int k = 0; k < 4; k++) for (int i = 0; i < 96; i++) m_bmp[k][i] = 0;
    m_gctl = 0;
  endtask

  function automatic int bank_of(int a);
    if (a < 12) return 0;
    if (a >= 16 && a < 28) return 1;
    if (a >= 128 && a < 140) return 2;
    if (a >= 144 && a < 156) return 3;
    return -1;
  endfunction

  function automatic bit [31:0] model_read(int a);
    bit [31:0] r = 0;
    int k, w, p;
    if (a % 4 != 0) return 0;
    if (a >= 256) begin
      p = (a - 256) / 8;
      if (p >= NP) return 0;
      if ((a - 256) % 8 == 0) begin
        r[31] = m_out[p]; r[30] = s2[p] && !m_off[p]; r[4] = m_trig[p];
        r[3] = m_inv[p]; r[2] = m_dir[p]; r[1:0] = m_use[p];
      end else begin
        r[2] = m_off[p]; r[1:0] = m_pull[p];
      end
      return r;
    end
    if (a == 124) return m_gctl;
    k = bank_of(a);
    if (k < 0) return 0;
    w = (a % 16) / 4;
    for (int b = 0; b < 32; b++) if (w*32 + b < NP) r[b] = m_bmp[k][w*32 + b];
    return r;
  endfunction

  task automatic model_write(int a, bit [31:0] d);
    int k, w, p;
    if (a % 4 != 0) return;
    if (a >= 256) begin
      p = (a - 256) / 8;
      if (p >= NP) return;
      if ((a - 256) % 8 == 0) begin
        m_out[p] = d[31]; m_trig[p] = d[4]; m_inv[p] = d[3]; m_dir[p] = d[2]; m_use[p] = d[1:0];
      end else begin
        m_off[p] = d[2]; m_pull[p] = d[1:0];
      end
      return;
    end
    if (a == 124) begin m_gctl = d; return; end
    k = bank_of(a);
    if (k < 0) return;
    w = (a % 16) / 4;
    for (int b = 0; b < 32; b++) begin
      if (w*32 + b < NP) begin
        if (k == 2) begin if (d[b]) m_bmp[2][w*32 + b] = 0; end
        else m_bmp[k][w*32 + b] = d[b];
      end
    end
  endtask

  // Cycle model: read, write, synchroniser shift, status set; then compare.
  always @(posedge clk) begin
    logic [NP-1:0] e_oe, e_out, e_tl, e_ti, e_st;
    logic [2*NP-1:0] e_mux, e_pull;
    if (!rst_n) begin
      model_reset();
      e_rvalid = 0;
    end else begin
      e_rvalid = bus_sel && !bus_write;
      if (e_rvalid) e_rdata = model_read(int'(bus_addr));
      if (bus_sel && bus_write) model_write(int'(bus_addr), bus_wdata);
      for (int p = 0; p < NP; p++) begin
        s2[p] = s1[p]; s1[p] = pad_in[p];
        if (irq_set[p]) m_bmp[2][p] = 1;
      end
    end
    #(CLK_PERIOD/4);
    for (int p = 0; p < NP; p++) begin
      e_oe[p] = (m_use[p] == 2'd1) && (m_dir[p] == 0);
      e_out[p] = m_out[p]; e_tl[p] = m_trig[p]; e_ti[p] = m_inv[p]; e_st[p] = m_bmp[2][p];
      e_mux[2*p +: 2] = m_use[p]; e_pull[2*p +: 2] = m_pull[p];
    end
    check("R9", "rvalid", 192'(bus_rvalid), 192'(e_rvalid));
    if (e_rvalid) check(phase, "rdata", 192'(bus_rdata), 192'(e_rdata));
    check("R5", "pad_oe", 192'(pad_oe), 192'(e_oe));
    check("R5", "pad_out", 192'(pad_out), 192'(e_out));
    check("R6", "pad_mux", 192'(pad_mux), 192'(e_mux));
    check("R6", "pad_pull", 192'(pad_pull), 192'(e_pull));
    check("R3", "trig", 192'({trig_level, trig_invert}), 192'({e_tl, e_ti}));
    check("R8", "status", 192'(irq_status), 192'(e_st));
  end

  task automatic wr(int a, bit [31:0] d);
    bus_sel = 1; bus_write = 1; bus_addr = 10'(a); bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_write = 0;
  endtask

  task automatic rd(int a);
    bus_sel = 1; bus_write = 0; bus_addr = 10'(a);
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (CLK_PERIOD * 5000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    phase = "R1";
    rd(12'h100); rd(12'h104); rd(12'h3F0); rd(12'h3F4);
    rd(12'h000); rd(12'h010); rd(12'h080); rd(12'h090); rd(12'h07C);

    phase = "R2";
    wr(12'h008, 32'hFFFF_FFFF); rd(12'h008);
    wr(12'h004, 32'hA5A5_0F0F); rd(12'h004); rd(12'h000);
    wr(12'h014, 32'h1234_8001); rd(12'h014);
    wr(12'h094, 32'h8000_0001); wr(12'h098, 32'hC000_0003);
    rd(12'h090); rd(12'h094); rd(12'h098);
    wr(12'h07C, 32'h1234_5678); rd(12'h07C);

    phase = "R3";
    wr(12'h128, 32'h8000_001D); rd(12'h128);
    wr(12'h3F0, 32'h0000_0011); rd(12'h3F0);
    wr(12'h3F0, 32'h8000_000A); rd(12'h3F0);

    phase = "R5";
    wr(12'h118, 32'h8000_0001); rd(12'h118);
    wr(12'h118, 32'h8000_0002); idle(1);
    wr(12'h118, 32'h0000_0001); idle(1);
    wr(12'h118, 32'h0000_0005); idle(1);

    phase = "R6";
    wr(12'h154, 32'h0000_0002); wr(12'h15C, 32'h0000_0001);
    wr(12'h160, 32'h0000_0003); rd(12'h154); rd(12'h15C); rd(12'h160);

    phase = "R4";
    pad_in = {NP{1'b1}};
    idle(3); rd(12'h1A0);
    wr(12'h1A4, 32'h0);
    rd(12'h1A0);
    pad_in[20] = 0; rd(12'h1A0); rd(12'h1A0); rd(12'h1A0);
    pad_in[20] = 1; rd(12'h1A0); rd(12'h1A0); rd(12'h1A0);
    wr(12'h1A0, 32'h4000_0000); rd(12'h1A0);
    pad_in[20] = 0; idle(3);
    wr(12'h1A0, 32'h4000_0004); rd(12'h1A0);
    pad_in[20] = 1; idle(3); rd(12'h1A0);
    wr(12'h1A4, 32'h4); rd(12'h1A0);
    pad_in = '0;

    phase = "R7";
    wr(12'h00C, 32'hFFFF_FFFF); wr(12'h040, 32'hFFFF_FFFF);
    wr(12'h102, 32'hFFFF_FFFF); wr(12'h3F8, 32'hFFFF_FFFF); wr(12'h3FC, 32'hFFFF_FFFF);
    wr(12'h07D, 32'h0);
    rd(12'h00C); rd(12'h040); rd(12'h102); rd(12'h3F8); rd(12'h3FC); rd(12'h0A0);
    rd(12'h000); rd(12'h100); rd(12'h07C);

    phase = "R8";
    irq_set[2] = 1; irq_set[70] = 1; @(negedge clk); irq_set = '0;
    rd(12'h080); rd(12'h088); idle(2); rd(12'h080);
    wr(12'h080, 32'h0000_0004); rd(12'h080); rd(12'h088);
    irq_set[70] = 1; wr(12'h088, 32'h0000_0040); irq_set = '0; rd(12'h088);
    wr(12'h088, 32'hFFFF_FFFF); rd(12'h088);

    phase = "R9";
    rd(12'h004); rd(12'h014); rd(12'h07C); idle(2);
    bus_sel = 1; bus_write = 0; bus_addr = 10'h104; @(negedge clk);
    bus_write = 1; bus_wdata = 32'h2; @(negedge clk);
    bus_write = 0; @(negedge clk);
    bus_sel = 0; idle(2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule